// File: doc/BRIEF.md
# Conversion Offset and Gain Corrector

This block sits between a converter and its result register. It takes each raw unsigned conversion code and adds a signed calibration offset to it. It then scales the sum by an unsigned fixed-point gain that has one integer bit and a fraction field. The block rounds the scaled value to the nearest integer and clamps it into the unsigned result range. The offset and the gain are sampled in the same cycle as the conversion they apply to, so they may change from one sample to the next without mixing the calibration of neighbouring samples.

With correction enabled, every accepted sample takes a fixed number of cycles to reach the output. The stage accepts one sample per cycle, so a continuous stream pays this delay only once, at its start. With correction disabled, the raw code and its strobe pass straight to the output in the same cycle. Any samples still inside the pipeline at that moment are dropped.

Top module: `adc_corr_pipe`

## Requirements
- R1: While `rst_n` is low, and in the cycles after its release until a sample is accepted, `out_valid` is 0. With correction enabled, `out_data` is 0 during reset.
- R2: With correction enabled, the offset is read as a 12-bit two's-complement number and added to the raw code before scaling. With gain 0x800, the output is raw plus offset.
- R3: The gain is an unsigned 12-bit code worth gain/2048, so 0x400 is one half and 0xFFF is just under two. The output is floor(((raw+offset)*gain + 1024) / 2048), meaning halves round up.
- R4: A corrected value below zero yields 0.
- R5: A corrected value above 4095 yields 4095.
- R6: With correction enabled, a sample strobed in cycle t appears in cycle t+13 with a one-cycle `out_valid` pulse. No other pulse results from it.
- R7: Samples strobed in consecutive cycles, or with gaps between them, come out in the same order with the same spacing. There is one output pulse per accepted sample.
- R8: With `corr_en` low, `out_valid` equals `raw_valid` and `out_data` equals `raw_data` in the same cycle, and the offset and gain have no effect. A cycle with `corr_en` low discards every sample still in flight, so none of them appears after correction is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| corr_en | input | 1 | 1: apply correction through the pipeline; 0: bypass and flush |
| offset | input | 12 | Signed offset added to the raw code, sampled with the strobe |
| gain | input | 12 | Unsigned gain with 11 fraction bits, sampled with the strobe |
| raw_valid | input | 1 | Strobe marking a raw conversion code |
| raw_data | input | 12 | Raw unsigned conversion code |
| out_valid | output | 1 | One-cycle strobe marking a corrected (or bypassed) code |
| out_data | output | 12 | Corrected or bypassed code |

## Verification
A table of calibration cases is streamed twice. The first pass is back-to-back and the second has three idle cycles between samples, so that both throughput and spacing are exercised along with the arithmetic. The cases are chosen to separate distinct faults:
- Unity gain with positive and negative offsets exposes wrong sign extension or a wrong order of operations.
- Half, one-and-a-half and near-two gains with odd raw codes expose truncation where rounding is required.
- Sums that go below zero or far above full scale exercise each clamp.
- An exactly full-scale product exercises the edge between rounding and saturation.

Directed cases then cover:
- A lone sample, which measures the latency and confirms there is one pulse.
- The bypass path, checked with a non-trivial offset and gain applied.
- A disable while a sample is still in flight.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
    // Default geometry of the correction stage.
    localparam int CORR_DW   = 12; // raw and result code width
    localparam int CORR_OW   = 12; // offset width, two's complement
    localparam int CORR_GW   = 12; // gain width, unsigned
    localparam int CORR_FRAC = 11; // fraction bits of the gain
    localparam int CORR_LAT  = 13; // total register stages, at least 3
endpackage

// File: rtl/corr_offset_stage.sv
module corr_offset_stage #(
    parameter int DW = 12,
    parameter int OW = 12,
    parameter int GW = 12,
    parameter int SW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          vld_i,
    input  logic [DW-1:0] raw_i,
    input  logic [OW-1:0] off_i,
    input  logic [GW-1:0] gain_i,
    output logic          vld_o,
    output logic [SW-1:0] sum_o,
    output logic [GW-1:0] gain_o
);
    typedef struct packed {
        logic          vld;
        logic [SW-1:0] sum;
        logic [GW-1:0] gain;
    } st_t;

    st_t st_d, st_q;
    logic signed [SW-1:0] raw_ext;
    logic signed [SW-1:0] off_ext;

    always_comb begin
        // raw is unsigned, offset sign-extended
        raw_ext     = {{(SW-DW){1'b0}}, raw_i};
        off_ext     = {{(SW-OW){off_i[OW-1]}}, off_i};
        st_d.vld    = vld_i & ~flush_i;
        st_d.sum    = raw_ext + off_ext;
        st_d.gain   = gain_i; // gain travels with its own sample
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign sum_o  = st_q.sum;
    assign gain_o = st_q.gain;
endmodule

// File: rtl/corr_gain_stage.sv
module corr_gain_stage #(
    parameter int SW = 14,
    parameter int GW = 12,
    parameter int PW = 27
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 vld_i,
    input  logic [SW-1:0]        sum_i,
    input  logic [GW-1:0]        gain_i,
    output logic                 vld_o,
    output logic signed [PW-1:0] prod_o
);
    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } st_t;

    st_t st_d, st_q;
    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;

    always_comb begin
        a_ext     = {{(PW-SW){sum_i[SW-1]}}, sum_i};
        b_ext     = {{(PW-GW){1'b0}}, gain_i};
        st_d.vld  = vld_i & ~flush_i;
        st_d.prod = a_ext * b_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign prod_o = $signed(st_q.prod);
endmodule

// File: rtl/corr_round_stage.sv
module corr_round_stage #(
    parameter int DW   = 12,
    parameter int PW   = 27,
    parameter int FRAC = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_i,
    input  logic                 vld_i,
    input  logic signed [PW-1:0] prod_i,
    output logic                 vld_o,
    output logic [DW-1:0]        res_o
);
    localparam int HALF   = 1 << (FRAC-1);
    localparam int MAXV   = (1 << DW) - 1;
    localparam int SAT_TH = MAXV << FRAC;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
    } st_t;

    st_t st_d, st_q;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] shf;

    always_comb begin
        rnd      = prod_i + $signed(PW'(HALF));
        shf      = rnd >>> FRAC;
        st_d.vld = vld_i & ~flush_i;
        if (shf < 0)
            st_d.res = '0;
        else if (shf > $signed(PW'(MAXV)))
            st_d.res = DW'(MAXV);
        else
            st_d.res = shf[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign res_o = st_q.res;

    // Negative products must clamp to zero.
    p_clamp_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_i < 0) |=> (res_o == '0));

    // Products beyond full scale must clamp to the maximum code.
    p_clamp_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_i > $signed(PW'(SAT_TH))) |=> (res_o == DW'(MAXV)));
endmodule

// File: rtl/corr_delay_line.sv
module corr_delay_line #(
    parameter int DW    = 12,
    parameter int DEPTH = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          vld_i,
    input  logic [DW-1:0] data_i,
    output logic          vld_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } st_t;

    generate
        if (DEPTH == 0) begin : g_none
            assign vld_o  = vld_i & ~flush_i;
            assign data_o = data_i;
        end else begin : g_regs
            st_t [DEPTH-1:0] st_d, st_q;

            always_comb begin
                st_d[0].vld  = vld_i;
                st_d[0].data = data_i;
                for (int i = 1; i < DEPTH; i++)
                    st_d[i] = st_q[i-1];
                for (int i = 0; i < DEPTH; i++)
                    st_d[i].vld = st_d[i].vld & ~flush_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign vld_o  = st_q[DEPTH-1].vld;
            assign data_o = st_q[DEPTH-1].data;
        end
    endgenerate
endmodule

// File: rtl/adc_corr_pipe.sv
module adc_corr_pipe
    import adc_corr_pkg::*;
#(
    parameter int DW   = CORR_DW,
    parameter int OW   = CORR_OW,
    parameter int GW   = CORR_GW,
    parameter int FRAC = CORR_FRAC,
    parameter int LAT  = CORR_LAT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          corr_en,
    input  logic [OW-1:0] offset,
    input  logic [GW-1:0] gain,
    input  logic          raw_valid,
    input  logic [DW-1:0] raw_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam int SW   = DW + 2;          // signed sum of raw and offset
    localparam int PW   = SW + GW + 1;     // signed product
    localparam int TAIL = LAT - 3;         // padding after the three arithmetic stages
    localparam int CW   = $clog2(LAT + 2); // in-flight counter width

    logic                 flush;
    logic                 s1_vld, s2_vld, s3_vld, pipe_vld;
    logic [SW-1:0]        s1_sum;
    logic [GW-1:0]        s1_gain;
    logic signed [PW-1:0] s2_prod;
    logic [DW-1:0]        s3_res, pipe_data;

    assign flush = ~corr_en;

    corr_offset_stage #(.DW(DW), .OW(OW), .GW(GW), .SW(SW)) u_off (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .vld_i(raw_valid), .raw_i(raw_data), .off_i(offset), .gain_i(gain),
        .vld_o(s1_vld), .sum_o(s1_sum), .gain_o(s1_gain));

    corr_gain_stage #(.SW(SW), .GW(GW), .PW(PW)) u_gain (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .vld_i(s1_vld), .sum_i(s1_sum), .gain_i(s1_gain),
        .vld_o(s2_vld), .prod_o(s2_prod));

    corr_round_stage #(.DW(DW), .PW(PW), .FRAC(FRAC)) u_rnd (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .vld_i(s2_vld), .prod_i(s2_prod),
        .vld_o(s3_vld), .res_o(s3_res));

    corr_delay_line #(.DW(DW), .DEPTH(TAIL)) u_dly (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .vld_i(s3_vld), .data_i(s3_res),
        .vld_o(pipe_vld), .data_o(pipe_data));

    always_comb begin
        if (corr_en) begin
            out_valid = pipe_vld;
            out_data  = pipe_data;
        end else begin
            out_valid = raw_valid;
            out_data  = raw_data;
        end
    end

    // Port-level count of samples accepted but not yet delivered.
    logic [CW-1:0] infl_d, infl_q;

    always_comb begin
        infl_d = infl_q;
        if (!corr_en)
            infl_d = '0;
        else
            infl_d = infl_q + CW'(raw_valid) - CW'(out_valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) infl_q <= '0;
        else        infl_q <= infl_d;
    end

    // Never more samples in flight than pipeline stages.
    p_inflight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        infl_q <= CW'(LAT));

    // An enabled output pulse always belongs to an accepted sample.
    p_no_phantom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_en && out_valid) |-> (infl_q != '0));
endmodule

// File: tb/adc_corr_pipe_tb_top.sv
module adc_corr_pipe_tb_top;
    localparam int NV  = 14;
    localparam int LAT = 13;

    // {raw, offset, gain, expected}
    localparam logic [47:0] VEC [NV] = '{
        {12'd1000, 12'h000, 12'h800, 12'd1000}, // R3 unity
        {12'd1000, 12'h064, 12'h800, 12'd1100}, // R2 +100
        {12'd1000, 12'hF9C, 12'h800, 12'd900 }, // R2 -100
        {12'd1000, 12'h000, 12'h400, 12'd500 }, // R3 half
        {12'd1001, 12'h000, 12'h400, 12'd501 }, // R3 500.5 rounds up
        {12'd1000, 12'h000, 12'hC00, 12'd1500}, // R3 1.5x
        {12'd3,    12'h000, 12'hFFF, 12'd6   }, // R3 near-two gain
        {12'd10,   12'hFEC, 12'h800, 12'd0   }, // R4 negative clamps
        {12'd4000, 12'h000, 12'hFFF, 12'd4095}, // R5 high clamp
        {12'd2048, 12'h000, 12'hFFF, 12'd4095}, // R3 exact full scale
        {12'd4095, 12'h800, 12'h800, 12'd2047}, // R2 most negative offset
        {12'd0,    12'h7FF, 12'h800, 12'd2047}, // R2 most positive offset
        {12'd5,    12'h000, 12'h400, 12'd3   }, // R3 2.5 rounds up
        {12'd4095, 12'h7FF, 12'hFFF, 12'd4095}  // R5 both extremes
    };
    localparam int VREQ [NV] = '{3, 2, 2, 3, 3, 3, 3, 4, 5, 3, 2, 2, 3, 5};

    logic        clk = 1'b0;
    logic        rst_n, corr_en, raw_valid;
    logic [11:0] offset, gain, raw_data;
    logic        out_valid;
    logic [11:0] out_data;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0, collect = 0;
    int out_idx = 0;
    int issue_cyc [NV];

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    adc_corr_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .corr_en(corr_en), .offset(offset), .gain(gain),
        .raw_valid(raw_valid), .raw_data(raw_data),
        .out_valid(out_valid), .out_data(out_data));

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Output collector for the table passes (R6, R7).
    always @(negedge clk) begin
        if (collect && out_valid) begin
            if (out_idx < NV) begin
                check(out_data == VEC[out_idx][11:0], VREQ[out_idx], "table data",
                      int'(out_data), int'(VEC[out_idx][11:0]));
                check(cyc == issue_cyc[out_idx] + LAT, 6, "table latency",
                      cyc, issue_cyc[out_idx] + LAT);
            end
            out_idx++;
        end
    end

    task automatic run_pass(input int gap);
        out_idx = 0;
        collect = 1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            raw_valid = 1'b1;
            raw_data  = VEC[i][47:36];
            offset    = VEC[i][35:24];
            gain      = VEC[i][23:12];
            issue_cyc[i] = cyc;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                raw_valid = 1'b0;
                offset    = 12'h5A5; // later calibration must not leak back
                gain      = 12'h400;
            end
        end
        @(negedge clk);
        raw_valid = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        collect = 0;
        check(out_idx == NV, 7, "output pulse count", out_idx, NV); // R7
    endtask

    initial begin
        int pulses, pcyc, pdata, t;
        rst_n = 1'b0; corr_en = 1'b1; raw_valid = 1'b1;
        raw_data = 12'd5; offset = 12'h000; gain = 12'h800;
        // R1: nothing emerges while reset is held
        repeat (LAT + 2) @(negedge clk);
        check(out_valid == 1'b0, 1, "valid in reset", int'(out_valid), 0);
        check(out_data == 12'd0, 1, "data in reset", int'(out_data), 0);
        raw_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pulses = 0;
        repeat (LAT + 2) begin
            @(negedge clk);
            if (out_valid) pulses++;
        end
        check(pulses == 0, 1, "pulses after reset", pulses, 0); // R1

        // R7: back-to-back stream, then spaced stream
        run_pass(0);
        run_pass(3);

        // R6: lone sample, latency and single pulse
        @(negedge clk);
        raw_valid = 1'b1; raw_data = 12'd100; offset = 12'h000; gain = 12'h800;
        t = cyc;
        @(negedge clk);
        raw_valid = 1'b0;
        pulses = 0; pcyc = -1; pdata = -1;
        repeat (LAT + 6) begin
            if (out_valid) begin pulses++; pcyc = cyc; pdata = int'(out_data); end
            @(negedge clk);
        end
        check(pulses == 1, 6, "lone pulse count", pulses, 1);
        check(pcyc == t + LAT, 6, "lone latency", pcyc, t + LAT);
        check(pdata == 100, 6, "lone data", pdata, 100);

        // R8: bypass is immediate and ignores calibration
        corr_en = 1'b0; offset = 12'h7FF; gain = 12'h400;
        @(negedge clk);
        raw_valid = 1'b1; raw_data = 12'hABC;
        #1;
        check(out_valid == 1'b1, 8, "bypass valid", int'(out_valid), 1);
        check(out_data == 12'hABC, 8, "bypass data", int'(out_data), 'hABC);
        raw_data = 12'h005;
        #1;
        check(out_data == 12'h005, 8, "bypass data 2", int'(out_data), 5);
        raw_valid = 1'b0;
        #1;
        check(out_valid == 1'b0, 8, "bypass idle", int'(out_valid), 0);

        // R8: disable while a sample is in flight discards it
        @(negedge clk);
        corr_en = 1'b1; raw_valid = 1'b1; raw_data = 12'd200;
        offset = 12'h000; gain = 12'h800;
        @(negedge clk);
        raw_valid = 1'b0;
        repeat (5) @(negedge clk);
        corr_en = 1'b0;
        @(negedge clk);
        corr_en = 1'b1;
        pulses = 0;
        repeat (LAT + 4) begin
            @(negedge clk);
            if (out_valid) pulses++;
        end
        check(pulses == 0, 8, "flushed sample reappeared", pulses, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule